// File: doc/BRIEF.md
# Filtered Sliding-Window Payload Hasher

This block watches a stream of payload bytes, four per clock, and produces hash values that a later counting stage can use to spot content that repeats often. Bytes that carry little meaning in binary payloads (zero, line feed and horizontal tab) are removed first. So are bytes whose per-byte valid flag is low. The bytes that remain are packed together in stream order and pushed into a ten-byte history. Each byte that survives closes one new ten-byte window. Every such window is hashed, so a clock yields from zero to four results.

Each hash bit is the parity of a chosen subset of the eighty window bits. The subsets come from a mask matrix held in the block. Configuration fills it with random rows before traffic starts, so an attacker cannot predict which strings will collide. The windows are reported beside their hashes, so a downstream stage can keep the actual string that caused a hit.

Top module: `filtered_window_hasher`

## Requirements
- R1: A byte is dropped when its `in_bvalid` bit is 0 or its value is 8'h00, 8'h0A or 8'h09. A dropped byte never appears in any window and produces no hash.
- R2: Byte b of `in_data` sits at bits [8b+7:8b], and byte 0 is earliest in the stream. The surviving bytes of a word enter the history in that order, and the history advances by exactly the number of survivors (0 to 4).
- R3: Each surviving byte yields one lane whose window ends with that byte. Lane 0 carries the oldest new window of the clock. Lane l's window is `out_win[80l+79:80l]` and its hash is `out_hash[16l+15:16l]`.
- R4: A lane is marked valid only if its byte is at least the tenth surviving byte since reset or since the last clear. The valid lanes of one clock form one contiguous run.
- R5: In a window, byte p (p=0 oldest, p=9 newest) occupies bits [8p+7:8p]. Hash bit j is the XOR, over all window bits a that are 1, of bit j of mask row a.
- R6: A word sampled at rising edge n drives the outputs right after edge n+2. This gives one register each for filtering, shifting and hashing.
- R7: A pulse on `cfg_we` with `cfg_addr` below 80 writes `cfg_row` into mask row `cfg_addr`, but only when `in_bvalid` is all zero in that cycle. Otherwise, and for addresses of 80 or above, the write has no effect. All mask rows are zero after reset.
- R8: `clear` empties the history, discards bytes still in flight, drops every output valid on the next edge and restarts the ten-byte warm-up. The mask is kept.
- R9: After reset, every `out_valid` bit is 0, and `out_hash` and `out_win` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Stream clear: empties history and pipeline, keeps mask |
| in_data | input | 32 | Four payload bytes, byte 0 earliest |
| in_bvalid | input | 4 | Per-byte valid flags |
| cfg_we | input | 1 | Mask row write strobe |
| cfg_addr | input | 7 | Window bit index of the row being written |
| cfg_row | input | 16 | Mask row: bit j enables this window bit for hash bit j |
| out_valid | output | 4 | Per-lane result valid |
| out_hash | output | 64 | Four 16-bit hash lanes |
| out_win | output | 320 | Four 80-bit windows matching the hash lanes |

## Verification
Corner cases occur at the boundaries the filter creates: warm-up completing in the middle of a word, so that a high lane is valid while a lower lane is not, and a filler placed between survivors, which has to close up without leaving a gap. Directed words place the tenth survivor in lane 1 and put a line feed in byte 1. A long random run then mixes fillers, cleared flags, clears at arbitrary points and busy-cycle mask writes. A behavioural byte-queue model checks all of it on every clock, using random mask rows loaded while the stream is idle.

// File: rtl/filtered_window_hasher.sv
module filtered_window_hasher #(
  parameter int HASH_W    = 16,
  parameter int LANES     = 4,
  parameter int WIN_BYTES = 10
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 clear,
  input  logic [LANES*8-1:0]                   in_data,
  input  logic [LANES-1:0]                     in_bvalid,
  input  logic                                 cfg_we,
  input  logic [$clog2(WIN_BYTES*8)-1:0]       cfg_addr,
  input  logic [HASH_W-1:0]                    cfg_row,
  output logic [LANES-1:0]                     out_valid,
  output logic [LANES*HASH_W-1:0]              out_hash,
  output logic [LANES*WIN_BYTES*8-1:0]         out_win
);
  localparam int WIN_W = WIN_BYTES * 8;
  localparam int HIST  = WIN_BYTES - 1;
  localparam int EXT   = HIST + LANES;
  localparam int CW    = $clog2(WIN_BYTES + 1);

  function automatic logic is_filler(input logic [7:0] b);
    return (b == 8'h00) || (b == 8'h0A) || (b == 8'h09);
  endfunction

  // filter stage
  logic [LANES-1:0]   fill_hit;
  logic [LANES-1:0]   s1_keep;
  logic [LANES*8-1:0] s1_data;

  for (genvar b = 0; b < LANES; b++) begin : g_filt
    assign fill_hit[b] = is_filler(in_data[8*b +: 8]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      s1_keep <= '0;
      s1_data <= '0;
    end else begin
      s1_keep <= in_bvalid & ~fill_hit;
      s1_data <= in_data;
    end
  end

  // shift stage
  logic [7:0]             ext [EXT];
  logic [8*HIST-1:0]      hist, hist_nxt;
  logic [CW-1:0]          fill, fill_nxt;
  logic [LANES-1:0]       win_ok, s2_valid;
  logic [LANES*WIN_W-1:0] win_nxt, s2_win;

  always_comb begin
    int k;
    k = HIST;
    for (int p = 0; p < HIST; p++) ext[p] = hist[8*p +: 8];
    for (int p = HIST; p < EXT; p++) ext[p] = 8'h00;
    for (int b = 0; b < LANES; b++) begin
      if (s1_keep[b]) begin
        ext[k] = s1_data[8*b +: 8];
        k++;
      end
    end
    for (int p = 0; p < HIST; p++) hist_nxt[8*p +: 8] = ext[p + k - HIST];
    for (int l = 0; l < LANES; l++) begin
      win_ok[l] = (l < k - HIST) && (int'(fill) + l + 1 >= WIN_BYTES);
      for (int p = 0; p < WIN_BYTES; p++) win_nxt[l*WIN_W + 8*p +: 8] = ext[l + p];
    end
    fill_nxt = (int'(fill) + k - HIST >= WIN_BYTES) ? CW'(WIN_BYTES) : CW'(int'(fill) + k - HIST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      hist     <= '0;
      fill     <= '0;
      s2_valid <= '0;
      s2_win   <= '0;
    end else begin
      hist     <= hist_nxt;
      fill     <= fill_nxt;
      s2_valid <= win_ok;
      s2_win   <= win_nxt;
    end
  end

  // mask matrix
  logic [HASH_W-1:0] mask [WIN_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < WIN_W; a++) mask[a] <= '0;
    end else if (cfg_we && in_bvalid == '0 && int'(cfg_addr) < WIN_W) begin
      mask[cfg_addr] <= cfg_row;
    end
  end

  // hash stage
  logic [LANES*HASH_W-1:0] hash_nxt;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      hash_nxt[l*HASH_W +: HASH_W] = '0;
      for (int a = 0; a < WIN_W; a++)
        if (s2_win[l*WIN_W + a]) hash_nxt[l*HASH_W +: HASH_W] ^= mask[a];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      out_valid <= '0;
      out_hash  <= '0;
      out_win   <= '0;
    end else begin
      out_valid <= s2_valid;
      out_hash  <= hash_nxt;
      out_win   <= s2_win;
    end
  end

  // checks
  function automatic logic win_clean(input logic [WIN_W-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int p = 0; p < WIN_BYTES; p++) if (is_filler(w[8*p +: 8])) ok = 1'b0;
    return ok;
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    a_r1_no_filler: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[l] |-> win_clean(out_win[l*WIN_W +: WIN_W]));
    if (l < LANES - 1) begin : g_pair
      a_r3_slide: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[l] && out_valid[l+1]) |->
          out_win[(l+1)*WIN_W +: WIN_W-8] == out_win[l*WIN_W + 8 +: WIN_W-8]);
      a_r4_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[l] && !out_valid[l+1]) |-> ((out_valid >> (l+1)) == '0));
    end
  end

  a_r7_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && in_bvalid != '0 && int'(cfg_addr) < WIN_W) |=>
      mask[$past(cfg_addr)] == $past(mask[cfg_addr]));

  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> out_valid == '0);

endmodule

// File: tb/filtered_window_hasher_bench.sv
module filtered_window_hasher_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clear = 1'b0;
  logic [31:0]  in_data = '0;
  logic [3:0]   in_bvalid = '0;
  logic         cfg_we = 1'b0;
  logic [6:0]   cfg_addr = '0;
  logic [15:0]  cfg_row = '0;
  logic [3:0]   out_valid;
  logic [63:0]  out_hash;
  logic [319:0] out_win;

  filtered_window_hasher u_filtered_window_hasher (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_data(in_data), .in_bvalid(in_bvalid),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_row(cfg_row),
    .out_valid(out_valid), .out_hash(out_hash), .out_win(out_win));

  always #5 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [3:0]  pv [3];
  logic [79:0] pw [3][4];
  logic [15:0] bm [80];
  logic [7:0]  mq [$];
  int          mfill;

  function automatic logic [15:0] ref_hash(input logic [79:0] w);
    logic [15:0] h;
    h = '0;
    for (int j = 0; j < 16; j++)
      for (int a = 0; a < 80; a++) h[j] = h[j] ^ (w[a] & bm[a][j]);
    return h;
  endfunction

  always @(posedge clk) begin
    logic [3:0]  nv;
    logic [79:0] nw [4];
    logic [7:0]  c;
    int          lane;
    nv = '0;
    for (int l = 0; l < 4; l++) nw[l] = '0;
    if (!rst_n || clear) begin
      for (int s = 0; s < 3; s++) begin
        pv[s] = '0;
        for (int l = 0; l < 4; l++) pw[s][l] = '0;
      end
      mq.delete();
      mfill = 0;
      if (!rst_n) for (int a = 0; a < 80; a++) bm[a] = '0;
    end
    if (rst_n && cfg_we && in_bvalid == 4'h0 && cfg_addr < 7'd80) bm[cfg_addr] = cfg_row;
    if (rst_n && !clear) begin
      lane = 0;
      for (int b = 0; b < 4; b++) begin
        c = in_data[8*b +: 8];
        if (in_bvalid[b] && c != 8'h00 && c != 8'h0A && c != 8'h09) begin
          mq.push_back(c);
          mfill++;
          if (mq.size() > 10) void'(mq.pop_front());
          if (mfill >= 10) begin
            nv[lane] = 1'b1;
            for (int p = 0; p < 10; p++) nw[lane][8*p +: 8] = mq[p];
          end
          lane++;
        end
      end
      pv[2] = pv[1];
      pv[1] = pv[0];
      pv[0] = nv;
      for (int l = 0; l < 4; l++) begin
        pw[2][l] = pw[1][l];
        pw[1][l] = pw[0][l];
        pw[0][l] = nw[l];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < 4; l++) begin
        chk(out_valid[l] == pv[2][l], "R4 lane valid vs model", 80'(out_valid[l]), 80'(pv[2][l]));
        if (out_valid[l] && pv[2][l]) begin
          chk(out_win[80*l +: 80] == pw[2][l], "R2 window vs model", out_win[80*l +: 80], pw[2][l]);
          chk(out_hash[16*l +: 16] == ref_hash(pw[2][l]), "R5 hash vs model",
              80'(out_hash[16*l +: 16]), 80'(ref_hash(pw[2][l])));
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic step(input logic [31:0] d, input logic [3:0] v);
    in_data = d;
    in_bvalid = v;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(32'h0, 4'h0);
  endtask

  task automatic pulse_clear();
    clear = 1'b1;
    step(32'h0, 4'h0);
    clear = 1'b0;
  endtask

  task automatic write_row(input logic [6:0] a, input logic [15:0] r, input logic [31:0] d, input logic [3:0] v);
    cfg_we = 1'b1;
    cfg_addr = a;
    cfg_row = r;
    step(d, v);
    cfg_we = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk(out_valid == 4'h0, "R9 reset valid", 80'(out_valid), 80'h0);
    chk(out_hash == 64'h0, "R9 reset hash", 80'(out_hash), 80'h0);

    // R7: busy write ignored; R4: warm-up completes in lane 1
    pulse_clear();
    write_row(7'd0, 16'h0001, 32'h01010101, 4'hF);
    step(32'h01010101, 4'hF);
    step(32'h00000101, 4'h3);
    idle(2);
    chk(out_valid == 4'b0010, "R4 tenth byte lands in lane 1", 80'(out_valid), 80'h2);
    chk(out_hash[31:16] == 16'h0, "R7 busy write ignored", 80'(out_hash[31:16]), 80'h0);

    // R7 idle write takes effect, R5 hash value
    write_row(7'd0, 16'h0001, 32'h0, 4'h0);
    write_row(7'd90, 16'hFFFF, 32'h0, 4'h0);
    idle(3);
    pulse_clear();
    step(32'h01010101, 4'hF);
    step(32'h01010101, 4'hF);
    step(32'h00000101, 4'h3);
    idle(2);
    chk(out_valid == 4'b0010, "R4 warm-up after clear", 80'(out_valid), 80'h2);
    chk(out_hash[31:16] == 16'h0001, "R5 single mask row hash", 80'(out_hash[31:16]), 80'h1);

    // R8: clear restarts warm-up
    step(32'h11111111, 4'hF);
    pulse_clear();
    step(32'h22222222, 4'hF);
    step(32'h22222222, 4'hF);
    step(32'h00000023, 4'h1);
    for (int i = 0; i < 3; i++) begin
      idle(1);
      chk(out_valid == 4'h0, "R8 nine bytes after clear", 80'(out_valid), 80'h0);
    end
    step(32'h00000030, 4'h1);
    idle(2);
    chk(out_valid == 4'b0001, "R8 tenth byte after clear", 80'(out_valid), 80'h1);
    chk(out_win[79:72] == 8'h30, "R8 newest byte", 80'(out_win[79:72]), 80'h30);

    // R6 latency and R3 lane order
    step(32'h44434241, 4'hF);
    idle(1);
    chk(out_valid == 4'h0, "R6 not yet after one edge", 80'(out_valid), 80'h0);
    idle(1);
    chk(out_valid == 4'hF, "R6 valid after second edge", 80'(out_valid), 80'hF);
    for (int l = 0; l < 4; l++)
      chk(out_win[80*l + 72 +: 8] == 8'(8'h41 + l), "R3 lane order",
          80'(out_win[80*l + 72 +: 8]), 80'(8'h41 + l));

    // R2 compaction around a line feed
    step(32'h53520A51, 4'hF);
    idle(2);
    chk(out_valid == 4'b0111, "R2 three survivors", 80'(out_valid), 80'h7);
    chk(out_win[79:72] == 8'h51, "R2 lane0 newest", 80'(out_win[79:72]), 80'h51);
    chk(out_win[159:152] == 8'h52, "R2 lane1 newest", 80'(out_win[159:152]), 80'h52);
    chk(out_win[239:232] == 8'h53, "R2 lane2 newest", 80'(out_win[239:232]), 80'h53);
    chk(out_win[71:64] == 8'h44, "R2 lane0 previous byte", 80'(out_win[71:64]), 80'h44);

    // R1 fillers and cleared flags
    step(32'h0A09000A, 4'hF);
    step(32'h77777777, 4'h0);
    idle(1);
    chk(out_valid == 4'h0, "R1 filler word", 80'(out_valid), 80'h0);
    idle(1);
    chk(out_valid == 4'h0, "R1 flagged-off word", 80'(out_valid), 80'h0);
    step(32'h00000061, 4'h1);
    idle(2);
    chk(out_valid == 4'b0001, "R1 next survivor", 80'(out_valid), 80'h1);
    chk(out_win[71:64] == 8'h53, "R1 dropped bytes absent", 80'(out_win[71:64]), 80'h53);

    // random masks, random traffic
    for (int a = 0; a < 80; a++) write_row(7'(a), 16'($urandom), 32'h0, 4'h0);
    idle(3);
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      logic [3:0]  v;
      for (int b = 0; b < 4; b++) begin
        case ($urandom % 8)
          0: d[8*b +: 8] = 8'h00;
          1: d[8*b +: 8] = 8'h0A;
          2: d[8*b +: 8] = 8'h09;
          default: d[8*b +: 8] = 8'($urandom);
        endcase
      end
      v = 4'($urandom);
      if ($urandom % 10 == 0) v = 4'h0;
      if ($urandom % 6 == 0) v = 4'hF;
      clear = ($urandom % 64 == 0);
      if ($urandom % 16 == 0 && v != 4'h0) write_row(7'($urandom % 80), 16'($urandom), d, v);
      else step(d, v);
      clear = 1'b0;
    end
    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule